// File: doc/BRIEF.md
# Selectable-Period Watchdog Supervisor

This block is a watchdog timer that runs from a 32.768 kHz timebase. A 2-bit select code picks one of three timeout periods, or turns the watchdog off. The select code comes from a control register outside the block. The host keeps the watchdog quiet by pulsing a service strobe. If the host does not service it within the chosen period, the block raises a reset pulse of fixed length towards the host. When that pulse ends, the block starts timing again from zero.

The control logic is a three-state machine, with a cycle counter and a select tracker beside it:

- **DISABLED**: the counter is held at zero and the reset output is low.
- **WATCH**: the counter advances towards the terminal count of the current code.
- **BITE**: the reset output is high and the counter measures the pulse.

The transitions between the states are:

- **arm**: DISABLED to WATCH, when the code is anything other than 11.
- **service**: WATCH stays in WATCH with the counter cleared, on a strobe or on a change of code.
- **expire**: WATCH to BITE, when the terminal count is reached.
- **release**: BITE to WATCH, when the pulse length has elapsed.
- **disarm**: WATCH or BITE to DISABLED, when code 11 is applied.

The counts assume a 32768 Hz clock, and every count is a parameter.

Top module: `wdt_supervisor`

## Requirements
- R1: While the asynchronous reset `rst_ni` is low, `wdt_rst_o` is 0. After reset the block is in DISABLED, and the code it has tracked last is 11.
- R2: While `sel_i` is 11, the watchdog is disabled. `wdt_rst_o` is 0 from the next clock edge onward, and the counter is held at zero, so enabling the watchdog again always starts a full period.
- R3: With code 10, `wdt_rst_o` rises 8192 cycles after the last edge that cleared the counter.
- R4: With code 01, `wdt_rst_o` rises 24576 cycles after the last edge that cleared the counter.
- R5: With code 00, `wdt_rst_o` rises 57344 cycles after the last edge that cleared the counter. An edge that arms the watchdog from code 11 counts as a clearing edge.
- R6: A `kick_i` high at a clock edge in WATCH clears the counter, so no pulse occurs while the host keeps servicing the watchdog within the period.
- R7: A change of `sel_i` between two enabled codes, seen at an edge in WATCH, clears the counter. The new period then runs in full.
- R8: A reset pulse that is not disarmed lasts exactly 8192 cycles.
- R9: `kick_i` has no effect during BITE, and the pulse keeps its full length.
- R10: When a pulse is released, the counter restarts from zero. With no service, the next pulse rises one full period after the release edge.
- R11: Applying code 11 during BITE ends the pulse at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timebase clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sel_i | input | 2 | Period code: 00 = 1.75 s, 01 = 750 ms, 10 = 250 ms, 11 = off |
| kick_i | input | 1 | Service strobe from the host, sampled at each edge |
| wdt_rst_o | output | 1 | Reset pulse to the host, active high |

## Verification
Count the clock edge that samples a stimulus (a strobe, a new code or arming) as the clearing edge. `wdt_rst_o` is then first seen high exactly one period later, because the state register is the only register between the counter compare and the output. The pulse is first seen low exactly 8192 edges after it rose, or one edge after code 11 is applied during BITE. When the bench drives a stimulus, it records the edge count and pushes the expected rise cycle and pulse width into a queue. A monitor samples on the falling clock edge and compares each rise and each fall with the head of that queue. Any pulse the bench did not expect is reported as a failure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_DISABLED = 2'b00,
        ST_WATCH    = 2'b01,
        ST_BITE     = 2'b10
    } wdt_state_t;

    localparam logic [1:0] SEL_P0  = 2'b00;
    localparam logic [1:0] SEL_P1  = 2'b01;
    localparam logic [1:0] SEL_P2  = 2'b10;
    localparam logic [1:0] SEL_OFF = 2'b11;

    function automatic int unsigned wdt_max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_sel_track.sv
module wdt_sel_track
    import wdt_pkg::*;
#(
    parameter int unsigned T_P0  = 57344,
    parameter int unsigned T_P1  = 24576,
    parameter int unsigned T_P2  = 8192,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       sel_i,
    output logic             off_o,
    output logic             changed_o,
    output logic [CNT_W-1:0] term_o
);

    logic [1:0] sel_q;

    // Registered copy of the code; power-on value is the disabled code.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= SEL_OFF;
        end else begin
            sel_q <= sel_i;
        end
    end

    assign off_o     = (sel_i == SEL_OFF);
    assign changed_o = (sel_i != sel_q);

    // The terminal count comes from the registered code, so it is settled
    // by the time the counter runs under a new code.
    always_comb begin
        unique case (sel_q)
            SEL_P0:  term_o = CNT_W'(T_P0 - 1);
            SEL_P1:  term_o = CNT_W'(T_P1 - 1);
            SEL_P2:  term_o = CNT_W'(T_P2 - 1);
            default: term_o = '0;
        endcase
    end

    p_reset_code_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (sel_q == SEL_OFF) || rst_ni);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    p_clr_inc_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(clr_i && inc_i));

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PULSE_CYC = 8192
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             off_i,
    input  logic             changed_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] term_i,
    output wdt_state_t       state_o,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic             bite_o
);

    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

    wdt_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control.
    always_comb begin
        state_d   = state_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (state_q)
            ST_DISABLED: begin
                cnt_clr_o = 1'b1;
                if (!off_i) state_d = ST_WATCH;          // arm
            end
            ST_WATCH: begin
                if (off_i) begin                         // disarm
                    state_d   = ST_DISABLED;
                    cnt_clr_o = 1'b1;
                end else if (kick_i || changed_i) begin  // service
                    cnt_clr_o = 1'b1;
                end else if (cnt_i == term_i) begin      // expire
                    state_d   = ST_BITE;
                    cnt_clr_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_BITE: begin
                if (off_i) begin                         // disarm
                    state_d   = ST_DISABLED;
                    cnt_clr_o = 1'b1;
                end else if (cnt_i == PULSE_LAST) begin  // release
                    state_d   = ST_WATCH;
                    cnt_clr_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            default: begin
                state_d   = ST_DISABLED;
                cnt_clr_o = 1'b1;
            end
        endcase
    end

    // Outputs decoded from the state register.
    always_comb begin
        state_o = state_q;
        bite_o  = (state_q == ST_BITE);
    end

    p_bite_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BITE) |-> (cnt_i <= PULSE_LAST));

    p_bite_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BITE && !off_i && cnt_i != PULSE_LAST) |=> (state_q == ST_BITE));

    p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BITE && !off_i && cnt_i == PULSE_LAST)
            |=> (state_q == ST_WATCH && cnt_i == '0));

    p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BITE && off_i) |=> (state_q == ST_DISABLED));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int unsigned T_P0      = 57344,
    parameter int unsigned T_P1      = 24576,
    parameter int unsigned T_P2      = 8192,
    parameter int unsigned PULSE_CYC = 8192
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       kick_i,
    output logic       wdt_rst_o
);

    localparam int unsigned MAX_CNT = wdt_max2(wdt_max2(T_P0, T_P1), wdt_max2(T_P2, PULSE_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

    logic             off_w;
    logic             changed_w;
    logic [CNT_W-1:0] term_w;
    logic [CNT_W-1:0] cnt_w;
    logic             clr_w;
    logic             inc_w;
    wdt_state_t       state_w;

    wdt_sel_track #(
        .T_P0 (T_P0),
        .T_P1 (T_P1),
        .T_P2 (T_P2),
        .CNT_W(CNT_W)
    ) u_sel (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (sel_i),
        .off_o    (off_w),
        .changed_o(changed_w),
        .term_o   (term_w)
    );

    wdt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clr_w),
        .inc_i (inc_w),
        .cnt_o (cnt_w)
    );

    wdt_fsm #(
        .CNT_W    (CNT_W),
        .PULSE_CYC(PULSE_CYC)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .off_i    (off_w),
        .changed_i(changed_w),
        .kick_i   (kick_i),
        .cnt_i    (cnt_w),
        .term_i   (term_w),
        .state_o  (state_w),
        .cnt_clr_o(clr_w),
        .cnt_inc_o(inc_w),
        .bite_o   (wdt_rst_o)
    );

    always_comb begin
        if (!rst_ni) begin
            p_reset_low_r1: assert (wdt_rst_o == 1'b0);
        end
    end

    p_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_OFF) |=> (!wdt_rst_o && cnt_w == '0));

    p_watch_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_WATCH) |-> (cnt_w <= term_w));

    p_kick_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_WATCH && kick_i && sel_i != SEL_OFF)
            |=> (state_w == ST_WATCH && cnt_w == '0 && !wdt_rst_o));

    p_change_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_WATCH && changed_w && sel_i != SEL_OFF)
            |=> (cnt_w == '0 && !wdt_rst_o));

endmodule

// File: tb/wdt_supervisor_tb_top.sv
module wdt_supervisor_tb_top;

    localparam int P0    = 57344;
    localparam int P1    = 24576;
    localparam int P2    = 8192;
    localparam int PULSE = 8192;

    typedef struct {
        int    rise;
        int    width;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b11;
    logic       kick = 1'b0;
    logic       wdt_rst;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic prev = 1'b0;
    int   rise_at = 0;

    wdt_supervisor dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .sel_i    (sel),
        .kick_i   (kick),
        .wdt_rst_o(wdt_rst)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor: compares each observed pulse with the expectation queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst && !prev) begin
                rise_at = cyc;
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected pulse at cycle", cyc, -1);
                end else begin
                    check(cyc == exp_q[0].rise, exp_q[0].req, "rise cycle", cyc, exp_q[0].rise);
                end
            end
            if (!wdt_rst && prev && exp_q.size() > 0) begin
                check((cyc - rise_at) == exp_q[0].width, exp_q[0].req, "pulse width",
                      cyc - rise_at, exp_q[0].width);
                void'(exp_q.pop_front());
            end
            prev = wdt_rst;
        end
    end

    task automatic push(int rise, int width, string req);
        exp_t e;
        e.rise  = rise;
        e.width = width;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    // Drive a new code at a falling edge; return the cycle count there.
    task automatic set_sel(logic [1:0] code, output int at);
        @(negedge clk);
        sel = code;
        at  = cyc;
    endtask

    task automatic do_kick(output int at);
        @(negedge clk);
        kick = 1'b1;
        at   = cyc;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic quiet(int n, string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst) seen = 1'b1;
        end
        check(!seen, req, "output stayed low while disabled", int'(seen), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R1", "watchdog expired at cycle", cyc, 0);
        finish_run();
    end

    initial begin
        int t;
        int r;
        // R1: output low in reset
        repeat (3) @(negedge clk);
        check(wdt_rst == 1'b0, "R1", "output during reset", int'(wdt_rst), 0);
        rst_n = 1'b1;
        // R2: disabled code after reset keeps output quiet
        quiet(2000, "R2");

        // R3 period, R8 width, R10 restart after release
        set_sel(2'b10, t);
        push(t + 1 + P2, PULSE, "R3");
        push(t + 1 + P2 + PULSE + P2, PULSE, "R10");
        drain();
        set_sel(2'b11, t);
        quiet(2000, "R2");

        // R6 periodic service prevents the pulse; R9 kick ignored while biting
        set_sel(2'b10, t);
        for (int k = 0; k < 3; k++) begin
            repeat (3000) @(negedge clk);
            do_kick(t);
        end
        check(wdt_rst == 1'b0, "R6", "output after periodic service", int'(wdt_rst), 0);
        push(t + 1 + P2, PULSE, "R9");
        while (!wdt_rst) @(negedge clk);
        repeat (50) @(negedge clk);
        do_kick(r);
        drain();
        set_sel(2'b11, t);
        repeat (5) @(negedge clk);

        // R11 disabling during the pulse ends it one edge later
        set_sel(2'b10, t);
        r = t + 1 + P2;
        push(r, 101, "R11");
        while (cyc < r + 100) @(negedge clk);
        sel = 2'b11;
        drain();
        quiet(500, "R2");

        // R7 code change restarts the period; R4 period
        set_sel(2'b00, t);
        repeat (5000) @(negedge clk);
        set_sel(2'b01, t);
        push(t + 1 + P1, PULSE, "R7");
        drain();
        set_sel(2'b11, t);
        repeat (5) @(negedge clk);

        // R5 longest period
        set_sel(2'b00, t);
        push(t + 1 + P0, PULSE, "R5");
        drain();
        set_sel(2'b11, t);
        quiet(200, "R2");

        check(exp_q.size() == 0, "R8", "pending expected pulses", exp_q.size(), 0);
        finish_run();
    end

endmodule